// File: doc/BRIEF.md
# Paged Audio Register Access Decoder

This block is the register front end of a three-channel audio engine. It sits on a 256-byte I/O window as a slave and accepts byte, halfword and word accesses. It holds five registers of its own: control, a read-only status word, a 4-bit page number, a codec word and a serial-control word. Every access to a per-channel sample-count, frame-address or frame-count register is passed on to the channel engines over a narrow forwarding port. Read data from that port is returned on the bus.

The channel engines need more registers than the window has room for. The 16-byte slice at offsets 0x30 to 0x3F is therefore paged: the stored page number is placed above the low address byte before decoding. Page 0xC reaches the two playback channels' frame registers and page 0xD reaches the record channel's frame registers. A narrow write changes only the byte lanes it covers and leaves the rest of the target register as it was. A read returns its data in the cycle after the strobe.

Top module: `audio_reg_decoder`

## Requirements
- R1: Only address bits [7:0] are decoded. For offsets 0x30 to 0x3F the effective address is {page, offset}. Effective 0xC30/0xC34 are playback-0 frame address/count, 0xC38/0xC3C are playback-1 frame address/count, and 0xD30/0xD34 are record frame address/count. Any other page in that slice is unmapped.
- R2: Own registers sit at fixed offsets: control 0x00, status 0x04, page 0x0C, codec 0x10 and serial control 0x20. The sample counts of playback-0, playback-1 and record sit at 0x24, 0x28 and 0x2C.
- R3: A channel access raises ch_valid in the same cycle as the strobe, together with ch_we. The channel is given on ch_idx (0 playback-0, 1 playback-1, 2 record). The register is given on ch_kind (0 sample count, 1 frame address, 2 frame count). ch_be gives the byte enables and ch_wdata carries the write data shifted into its lane. The ch_rdata word is returned, aligned as in R9.
- R4: Size codes are 0 byte, 1 halfword, 2 or 3 word. The lane of a byte access is addr[1:0], a halfword covers lanes {addr[1],0} and {addr[1],1}, and a word covers all four. Write data is right-justified. A write to control, serial control, codec or page replaces only the covered lanes.
- R5: The page register holds 4 bits. A word write keeps only wdata[3:0].
- R6: A read of an unmapped offset returns 0xFFFFFFFF. So does a read of the phantom pair at effective 0xD38/0xD3C. Writes to the phantom pair are dropped and do not raise ch_valid.
- R7: A byte read of offset 0x1B returns 0x00000005. Other accesses to 0x18 to 0x1B are unmapped.
- R8: After reset, control reads 0x00000001, status reads 0x00000060, and page, codec and serial control read 0.
- R9: bus_rvalid is high exactly in the cycle after a read strobe, with bus_rdata valid there. Byte and halfword reads return the covered lanes right-justified and zero-extended.
- R10: Status is read-only: writes to offset 0x04 leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| bus_addr | input | ADDR_W | Byte address; only [7:0] is decoded |
| bus_wdata | input | 32 | Right-justified write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High in the cycle after a read strobe |
| ch_valid | output | 1 | Channel register access this cycle |
| ch_we | output | 1 | Channel access is a write |
| ch_idx | output | 2 | Channel: 0 playback-0, 1 playback-1, 2 record |
| ch_kind | output | 2 | 0 sample count, 1 frame address, 2 frame count |
| ch_be | output | 4 | Byte enables of the channel access |
| ch_wdata | output | 32 | Write data shifted into its lane |
| ch_rdata | input | 32 | Full word returned by the addressed channel register |

## Verification
The hardest state to reach is the frame-register selection. It exists only through the page register, so an address in the 0x30 to 0x3F slice means something different after each page write. The stimulus interleaves page writes with reads and writes in that slice. It visits an unmapped page, both frame pages and the phantom pair, and it also sets upper address bits. The bench drives ch_rdata from ch_idx and ch_kind, so every returned word shows which channel and register were chosen. Narrow writes in the bench are followed by word reads, which show that the untouched lanes kept their value.

// File: rtl/audreg_pkg.sv
package audreg_pkg;

    localparam int DATA_W = 32;
    localparam int PAGE_W = 4;
    localparam int EFF_W  = PAGE_W + 8;
    localparam int WIDX_W = EFF_W - 2;

    localparam logic [DATA_W-1:0] CTRL_RST = 32'h0000_0001;
    localparam logic [DATA_W-1:0] STAT_RST = 32'h0000_0060;
    localparam logic [DATA_W-1:0] LEGACY_VAL = 32'h0000_0005;

    // word indices of the effective (paged) address
    localparam logic [WIDX_W-1:0] W_CTRL   = 10'h000;
    localparam logic [WIDX_W-1:0] W_STAT   = 10'h001;
    localparam logic [WIDX_W-1:0] W_PAGE   = 10'h003;
    localparam logic [WIDX_W-1:0] W_CODEC  = 10'h004;
    localparam logic [WIDX_W-1:0] W_LEGACY = 10'h006;
    localparam logic [WIDX_W-1:0] W_SCTL   = 10'h008;
    localparam logic [WIDX_W-1:0] W_CNT0   = 10'h009;
    localparam logic [WIDX_W-1:0] W_CNT1   = 10'h00A;
    localparam logic [WIDX_W-1:0] W_CNT2   = 10'h00B;
    localparam logic [WIDX_W-1:0] W_P0_FA  = 10'h30C;
    localparam logic [WIDX_W-1:0] W_P0_FC  = 10'h30D;
    localparam logic [WIDX_W-1:0] W_P1_FA  = 10'h30E;
    localparam logic [WIDX_W-1:0] W_P1_FC  = 10'h30F;
    localparam logic [WIDX_W-1:0] W_RC_FA  = 10'h34C;
    localparam logic [WIDX_W-1:0] W_RC_FC  = 10'h34D;
    localparam logic [WIDX_W-1:0] W_PH_A   = 10'h34E;
    localparam logic [WIDX_W-1:0] W_PH_B   = 10'h34F;

    typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_WORD2 = 2'd3} size_e;

    typedef enum logic [3:0] {
        RG_CTRL, RG_STAT, RG_PAGE, RG_CODEC, RG_SCTL,
        RG_CHAN, RG_PHANTOM, RG_LEGACY, RG_NONE
    } region_e;

    typedef enum logic [1:0] {CK_COUNT = 2'd0, CK_FADDR = 2'd1, CK_FCNT = 2'd2, CK_RSVD = 2'd3} chan_kind_e;

    typedef struct packed {
        region_e    region;
        logic [1:0] chan_idx;
        chan_kind_e kind;
        logic [1:0] lane;
    } dec_t;

    function automatic logic [1:0] lane_of(size_e sz, logic [1:0] a);
        case (sz)
            SZ_BYTE: return a;
            SZ_HALF: return {a[1], 1'b0};
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [3:0] be_of(size_e sz, logic [1:0] lane);
        case (sz)
            SZ_BYTE: return 4'b0001 << lane;
            SZ_HALF: return 4'b0011 << lane;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] be_mask(logic [3:0] be);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{be[i]}};
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] merge_lanes(logic [DATA_W-1:0] old_v,
                                                      logic [DATA_W-1:0] wd,
                                                      size_e sz, logic [1:0] lane);
        logic [DATA_W-1:0] m;
        m = be_mask(be_of(sz, lane));
        return (old_v & ~m) | ((wd << {lane, 3'b000}) & m);
    endfunction

    function automatic logic [DATA_W-1:0] align_read(logic [DATA_W-1:0] w,
                                                     size_e sz, logic [1:0] lane);
        logic [DATA_W-1:0] s;
        s = w >> {lane, 3'b000};
        case (sz)
            SZ_BYTE: return {24'h0, s[7:0]};
            SZ_HALF: return {16'h0, s[15:0]};
            default: return w;
        endcase
    endfunction

endpackage

// File: rtl/addr_remap.sv
module addr_remap
    import audreg_pkg::*;
(
    input  logic [7:0]        off,
    input  logic [PAGE_W-1:0] page,
    input  size_e             size,
    output dec_t              dec
);
    logic [EFF_W-1:0] eff;
    logic [1:0]       lane;

    always_comb begin
        eff  = (off[7:4] == 4'h3) ? {page, off} : {{PAGE_W{1'b0}}, off};
        lane = lane_of(size, off[1:0]);
        dec  = '{region: RG_NONE, chan_idx: 2'd0, kind: CK_COUNT, lane: lane};
        case (eff[EFF_W-1:2])
            W_CTRL:   dec.region = RG_CTRL;
            W_STAT:   dec.region = RG_STAT;
            W_PAGE:   dec.region = RG_PAGE;
            W_CODEC:  dec.region = RG_CODEC;
            W_SCTL:   dec.region = RG_SCTL;
            W_LEGACY: dec.region = (size == SZ_BYTE && lane == 2'd3) ? RG_LEGACY : RG_NONE;
            W_CNT0:   begin dec.region = RG_CHAN; dec.chan_idx = 2'd0; dec.kind = CK_COUNT; end
            W_CNT1:   begin dec.region = RG_CHAN; dec.chan_idx = 2'd1; dec.kind = CK_COUNT; end
            W_CNT2:   begin dec.region = RG_CHAN; dec.chan_idx = 2'd2; dec.kind = CK_COUNT; end
            W_P0_FA:  begin dec.region = RG_CHAN; dec.chan_idx = 2'd0; dec.kind = CK_FADDR; end
            W_P0_FC:  begin dec.region = RG_CHAN; dec.chan_idx = 2'd0; dec.kind = CK_FCNT;  end
            W_P1_FA:  begin dec.region = RG_CHAN; dec.chan_idx = 2'd1; dec.kind = CK_FADDR; end
            W_P1_FC:  begin dec.region = RG_CHAN; dec.chan_idx = 2'd1; dec.kind = CK_FCNT;  end
            W_RC_FA:  begin dec.region = RG_CHAN; dec.chan_idx = 2'd2; dec.kind = CK_FADDR; end
            W_RC_FC:  begin dec.region = RG_CHAN; dec.chan_idx = 2'd2; dec.kind = CK_FCNT;  end
            W_PH_A, W_PH_B: dec.region = RG_PHANTOM;
            default:  dec.region = RG_NONE;
        endcase
    end
endmodule

// File: rtl/reg_store.sv
module reg_store
    import audreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  dec_t              dec,
    input  size_e             size,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] stat_q,
    output logic [PAGE_W-1:0] page_q,
    output logic [DATA_W-1:0] codec_q,
    output logic [DATA_W-1:0] sctl_q
);
    logic [DATA_W-1:0] page_merged;
    logic [DATA_W-1:0] wmask;

    assign page_merged = merge_lanes({{(DATA_W-PAGE_W){1'b0}}, page_q}, wdata, size, dec.lane);
    assign wmask       = be_mask(be_of(size, dec.lane));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= CTRL_RST;
            stat_q  <= STAT_RST;
            page_q  <= '0;
            codec_q <= '0;
            sctl_q  <= '0;
        end else if (wr_en) begin
            case (dec.region)
                RG_CTRL:  ctrl_q  <= merge_lanes(ctrl_q, wdata, size, dec.lane);
                RG_PAGE:  page_q  <= page_merged[PAGE_W-1:0];
                RG_CODEC: codec_q <= merge_lanes(codec_q, wdata, size, dec.lane);
                RG_SCTL:  sctl_q  <= merge_lanes(sctl_q, wdata, size, dec.lane);
                default:  ;
            endcase
        end
    end

    // R4
    ctrl_lane_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.region == RG_CTRL) |=>
        ((ctrl_q & ~$past(wmask)) == ($past(ctrl_q) & ~$past(wmask))));

    // R5
    page_word_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.region == RG_PAGE && size inside {SZ_WORD, SZ_WORD2}) |=>
        (page_q == $past(wdata[PAGE_W-1:0])));

    // R10
    status_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.region == RG_STAT) |=> $stable(stat_q));
endmodule

// File: rtl/read_path.sv
module read_path
    import audreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  dec_t              dec,
    input  size_e             size,
    input  logic [DATA_W-1:0] ctrl_q,
    input  logic [DATA_W-1:0] stat_q,
    input  logic [PAGE_W-1:0] page_q,
    input  logic [DATA_W-1:0] codec_q,
    input  logic [DATA_W-1:0] sctl_q,
    input  logic [DATA_W-1:0] ch_rdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    logic [DATA_W-1:0] word;
    logic [DATA_W-1:0] rd_next;

    always_comb begin
        word = '0;
        case (dec.region)
            RG_CTRL:  word = ctrl_q;
            RG_STAT:  word = stat_q;
            RG_PAGE:  word = {{(DATA_W-PAGE_W){1'b0}}, page_q};
            RG_CODEC: word = codec_q;
            RG_SCTL:  word = sctl_q;
            RG_CHAN:  word = ch_rdata;
            default:  word = '0;
        endcase
        case (dec.region)
            RG_NONE, RG_PHANTOM: rd_next = '1;
            RG_LEGACY:           rd_next = LEGACY_VAL;
            default:             rd_next = align_read(word, size, dec.lane);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_req;
            if (rd_req) rdata <= rd_next;
        end
    end

    // R9
    rvalid_rise_chk: assert property (@(posedge clk) disable iff (rst) rd_req |=> rvalid);
    // R9
    rvalid_idle_chk: assert property (@(posedge clk) disable iff (rst) !rd_req |=> !rvalid);
    // R6
    unmapped_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && dec.region inside {RG_NONE, RG_PHANTOM}) |=> (rdata == '1));
    // R7
    legacy_val_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && dec.region == RG_LEGACY) |=> (rdata == LEGACY_VAL));
endmodule

// File: rtl/audio_reg_decoder.sv
module audio_reg_decoder
    import audreg_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              ch_valid,
    output logic              ch_we,
    output logic [1:0]        ch_idx,
    output logic [1:0]        ch_kind,
    output logic [3:0]        ch_be,
    output logic [31:0]       ch_wdata,
    input  logic [31:0]       ch_rdata
);
    dec_t              dec;
    size_e             size;
    logic [DATA_W-1:0] ctrl_q, stat_q, codec_q, sctl_q;
    logic [PAGE_W-1:0] page_q;
    logic              unused_hi;

    assign size      = size_e'(bus_size);
    assign unused_hi = ^bus_addr[ADDR_W-1:8];

    addr_remap u_remap (
        .off  (bus_addr[7:0]),
        .page (page_q),
        .size (size),
        .dec  (dec)
    );

    reg_store u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_req && bus_we),
        .dec     (dec),
        .size    (size),
        .wdata   (bus_wdata),
        .ctrl_q  (ctrl_q),
        .stat_q  (stat_q),
        .page_q  (page_q),
        .codec_q (codec_q),
        .sctl_q  (sctl_q)
    );

    read_path u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_req   (bus_req && !bus_we),
        .dec      (dec),
        .size     (size),
        .ctrl_q   (ctrl_q),
        .stat_q   (stat_q),
        .page_q   (page_q),
        .codec_q  (codec_q),
        .sctl_q   (sctl_q),
        .ch_rdata (ch_rdata),
        .rdata    (bus_rdata),
        .rvalid   (bus_rvalid)
    );

    assign ch_valid = bus_req && (dec.region == RG_CHAN);
    assign ch_we    = bus_we;
    assign ch_idx   = dec.chan_idx;
    assign ch_kind  = dec.kind;
    assign ch_be    = be_of(size, dec.lane);
    assign ch_wdata = bus_wdata << {dec.lane, 3'b000};

    // R6
    phantom_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && dec.region == RG_PHANTOM) |-> !ch_valid);
    // R3
    ch_idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        ch_valid |-> (ch_idx != 2'd3 && ch_kind != 2'd3));
endmodule

// File: tb/tb_audio_reg_decoder.sv
`timescale 1ns/100ps
module tb_audio_reg_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [1:0]  bus_size = 2'd2;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        ch_valid, ch_we;
    logic [1:0]  ch_idx, ch_kind;
    logic [3:0]  ch_be;
    logic [31:0] ch_wdata, ch_rdata;

    int n_chk = 0;
    int n_bad = 0;

    logic        c_valid, c_we;
    logic [1:0]  c_idx, c_kind;
    logic [3:0]  c_be;
    logic [31:0] c_wdata;

    always #2.5 clk = ~clk;

    // channel engine model: word identifies channel and register
    assign ch_rdata = {6'b0, ch_idx, 6'b0, ch_kind, 16'hBEEF};

    audio_reg_decoder #(.ADDR_W(16)) dut (.*);

    // fields: tag, we, size, addr, wdata, expected read
    localparam int NV = 35;
    localparam logic [86:0] VEC [NV] = '{
        {4'd8, 1'b0, 2'd2, 16'h0000, 32'h0,        32'h0000_0001}, // R8
        {4'd8, 1'b0, 2'd2, 16'h0004, 32'h0,        32'h0000_0060}, // R8
        {4'd8, 1'b0, 2'd2, 16'h000C, 32'h0,        32'h0000_0000}, // R8
        {4'd8, 1'b0, 2'd2, 16'h0010, 32'h0,        32'h0000_0000}, // R8
        {4'd8, 1'b0, 2'd2, 16'h0020, 32'h0,        32'h0000_0000}, // R8
        {4'd4, 1'b1, 2'd0, 16'h0002, 32'h0000_00AB, 32'h0},        // R4
        {4'd4, 1'b0, 2'd2, 16'h0000, 32'h0,        32'h00AB_0001}, // R4
        {4'd4, 1'b1, 2'd1, 16'h0002, 32'h0000_1234, 32'h0},        // R4
        {4'd4, 1'b0, 2'd2, 16'h0000, 32'h0,        32'h1234_0001}, // R4
        {4'd9, 1'b0, 2'd0, 16'h0003, 32'h0,        32'h0000_0012}, // R9
        {4'd9, 1'b0, 2'd1, 16'h0002, 32'h0,        32'h0000_1234}, // R9
        {4'd9, 1'b0, 2'd0, 16'h0004, 32'h0,        32'h0000_0060}, // R9
        {4'd1, 1'b0, 2'd2, 16'hFF00, 32'h0,        32'h1234_0001}, // R1
        {4'd4, 1'b1, 2'd2, 16'h0020, 32'hDEAD_BEEF, 32'h0},        // R4
        {4'd4, 1'b1, 2'd0, 16'h0021, 32'h0000_0055, 32'h0},        // R4
        {4'd4, 1'b0, 2'd2, 16'h0020, 32'h0,        32'hDEAD_55EF}, // R4
        {4'd10,1'b1, 2'd2, 16'h0004, 32'hFFFF_FFFF, 32'h0},        // R10
        {4'd10,1'b0, 2'd2, 16'h0004, 32'h0,        32'h0000_0060}, // R10
        {4'd7, 1'b0, 2'd0, 16'h001B, 32'h0,        32'h0000_0005}, // R7
        {4'd6, 1'b0, 2'd2, 16'h0018, 32'h0,        32'hFFFF_FFFF}, // R6
        {4'd6, 1'b0, 2'd2, 16'h0008, 32'h0,        32'hFFFF_FFFF}, // R6
        {4'd5, 1'b1, 2'd2, 16'h000C, 32'hFFFF_FFF7, 32'h0},        // R5
        {4'd5, 1'b0, 2'd2, 16'h000C, 32'h0,        32'h0000_0007}, // R5
        {4'd1, 1'b0, 2'd2, 16'h0030, 32'h0,        32'hFFFF_FFFF}, // R1
        {4'd2, 1'b1, 2'd2, 16'h0010, 32'h0000_A5C3, 32'h0},        // R2
        {4'd2, 1'b0, 2'd2, 16'h0010, 32'h0,        32'h0000_A5C3}, // R2
        {4'd1, 1'b1, 2'd2, 16'h000C, 32'h0000_000C, 32'h0},        // R1
        {4'd3, 1'b0, 2'd2, 16'h0034, 32'h0,        32'h0002_BEEF}, // R3
        {4'd3, 1'b0, 2'd2, 16'h003C, 32'h0,        32'h0102_BEEF}, // R3
        {4'd3, 1'b0, 2'd2, 16'h0138, 32'h0,        32'h0101_BEEF}, // R3
        {4'd1, 1'b1, 2'd2, 16'h000C, 32'h0000_000D, 32'h0},        // R1
        {4'd3, 1'b0, 2'd2, 16'h0030, 32'h0,        32'h0201_BEEF}, // R3
        {4'd6, 1'b0, 2'd2, 16'h0038, 32'h0,        32'hFFFF_FFFF}, // R6
        {4'd3, 1'b0, 2'd1, 16'h002E, 32'h0,        32'h0000_0200}, // R3
        {4'd3, 1'b0, 2'd0, 16'h0029, 32'h0,        32'h0000_00BE}  // R3
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic we, input logic [1:0] sz, input logic [15:0] a,
                       input logic [31:0] wd);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = wd;
        #1;
        c_valid = ch_valid; c_we = ch_we; c_idx = ch_idx; c_kind = ch_kind;
        c_be = ch_be; c_wdata = ch_wdata;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R8 rvalid after reset", {31'b0, bus_rvalid}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [3:0]  tg;
            logic        we;
            logic [1:0]  sz;
            logic [15:0] a;
            logic [31:0] wd, ex;
            {tg, we, sz, a, wd, ex} = VEC[i];
            acc(we, sz, a, wd);
            if (!we) chk($sformatf("R%0d vector %0d", tg, i), bus_rdata, ex);
        end

        // R9 rvalid only after reads
        acc(1'b0, 2'd2, 16'h0000, 32'h0);
        chk("R9 rvalid after read", {31'b0, bus_rvalid}, 32'd1);
        chk("R3 no forward on own register", {31'b0, c_valid}, 32'd0);
        acc(1'b1, 2'd2, 16'h0010, 32'h0000_A5C3);
        chk("R9 rvalid after write", {31'b0, bus_rvalid}, 32'd0);

        // R6 phantom write dropped (page is D)
        acc(1'b1, 2'd2, 16'h003C, 32'h5555_AAAA);
        chk("R6 phantom write forward", {31'b0, c_valid}, 32'd0);
        acc(1'b0, 2'd2, 16'h003C, 32'h0);
        chk("R6 phantom read", bus_rdata, 32'hFFFF_FFFF);

        // R3 byte write to playback-0 sample count
        acc(1'b1, 2'd0, 16'h0025, 32'h0000_007E);
        chk("R3 cnt valid", {31'b0, c_valid}, 32'd1);
        chk("R3 cnt we", {31'b0, c_we}, 32'd1);
        chk("R3 cnt idx", {30'b0, c_idx}, 32'd0);
        chk("R3 cnt kind", {30'b0, c_kind}, 32'd0);
        chk("R3 cnt be", {28'b0, c_be}, 32'h2);
        chk("R3 cnt wdata", c_wdata, 32'h0000_7E00);

        // R3 word write to playback-0 frame address via page C
        acc(1'b1, 2'd2, 16'h000C, 32'h0000_000C);
        acc(1'b1, 2'd2, 16'h0030, 32'h1122_3344);
        chk("R3 fa valid", {31'b0, c_valid}, 32'd1);
        chk("R3 fa idx", {30'b0, c_idx}, 32'd0);
        chk("R3 fa kind", {30'b0, c_kind}, 32'd1);
        chk("R3 fa be", {28'b0, c_be}, 32'hF);
        chk("R3 fa wdata", c_wdata, 32'h1122_3344);

        // R8 reset in mid-run
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        chk("R8 rvalid cleared", {31'b0, bus_rvalid}, 32'd0);
        acc(1'b0, 2'd2, 16'h0000, 32'h0);
        chk("R8 ctrl after reset", bus_rdata, 32'h0000_0001);
        acc(1'b0, 2'd2, 16'h0020, 32'h0);
        chk("R8 sctl after reset", bus_rdata, 32'h0);
        acc(1'b0, 2'd2, 16'h000C, 32'h0);
        chk("R8 page after reset", bus_rdata, 32'h0);
        acc(1'b0, 2'd2, 16'h0010, 32'h0);
        chk("R8 codec after reset", bus_rdata, 32'h0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule